// File: doc/BRIEF.md
# Chunked Word Copy DMA Channel

This block is a single-channel copy engine. It moves a programmed number of 32-bit words from a source address to a destination address over a simple request/acknowledge memory port. Each word is fetched with one read, held in an internal register, and then stored with one write. Addresses advance by four bytes per word, or stay fixed, as software chooses.

Software sets up the channel through four registers: control/status, size, source and destination. Writing the start bit launches the copy. The copy is cut into chunks of a programmable length, and the engine drops its bus request for one cycle after each chunk so that other masters can win the bus. The channel reports busy, done and error status. It accepts a software stop, which ends the copy at the next word boundary with error set. It can raise one interrupt line on done, on error, or on both. Two interface-select bits are stored and driven out unchanged for the whole copy.

Register offsets on `reg_addr`: 0 is control/status, 1 is size, 2 is source address and 3 is destination address. Reads are combinational.

Top module: `word_dma_chan`

## Requirements
- R1: After reset, busy, done, error and the interrupt read 0 and no memory request is made. Writing 1 to control bit 0 while idle, with valid sizes, sets busy (status bit 10) at the same clock edge and raises a read request at the source address.
- R2: The size register holds the total word count in bits 12:0 and the chunk word count in bits 24:16. A transfer makes exactly that many word reads, each followed by a write of the same data word.
- R3: Control bit 4 set makes the read address step by 4 after every word, and control bit 3 does the same for the write address. A clear bit keeps that address fixed at its programmed value.
- R4: After every complete chunk that is not the last one, the request drops for exactly one cycle. A transfer of T words in chunks of C therefore shows ceil(T/C) request drops, and ceil(T/C)-1 idle cycles while words remain.
- R5: A start with a chunk count of 0 or above 256, or a total count of 0 or above 4096, makes no memory access, leaves busy clear and sets error (status bit 12). The values 256 and 4096 are accepted.
- R6: While busy, writes to the size, source and destination registers and to any control field other than stop are ignored.
- R7: When the last word is written, done (status bit 11) is set and busy clears at the same edge.
- R8: Writing control bit 9 while busy ends the transfer after the word in flight is written, sets error and leaves done clear. Done and error are never set together.
- R9: An error response on a memory access ends the transfer at once, sets error, and issues no further access.
- R10: The interrupt output is high when done is set with control bit 18 set, or when error is set with control bit 17 set. It is low otherwise.
- R11: Control bits 2 and 1 drive the source-select and destination-select outputs. These outputs hold steady for the whole transfer.
- R12: A new start clears done, error and the interrupt.
- R13: A request keeps its address and direction unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected register |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with the acknowledge |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access failed, valid with the acknowledge |
| src_sel | output | 1 | Stored source interface select |
| dst_sel | output | 1 | Stored destination interface select |
| irq | output | 1 | Channel interrupt |

## Verification
The checker watches several properties on every cycle. A pending request must hold its address and direction. Every write must directly follow an acknowledged read. Done and error may never be set together, and neither may show while busy. The interrupt stays quiet during a transfer, and the interface selects stay fixed. Other behaviours can only be shown by the bench's scenarios: exact word counts, address stepping per increment mode, the number and length of chunk gaps, rejection at the size limits, the stop boundary, error responses and ignored writes. The bench runs a sweep of totals, chunk sizes and increment modes against an arithmetic model of the expected addresses and data.

// File: rtl/wdma_pkg.sv
package wdma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_GAP} mv_state_t;

  localparam int CTL_GO      = 0;
  localparam int CTL_DSEL    = 1;
  localparam int CTL_SSEL    = 2;
  localparam int CTL_DINC    = 3;
  localparam int CTL_SINC    = 4;
  localparam int CTL_STOP    = 9;
  localparam int STA_BUSY    = 10;
  localparam int STA_DONE    = 11;
  localparam int STA_ERR     = 12;
  localparam int CTL_IE_ERR  = 17;
  localparam int CTL_IE_DONE = 18;

  localparam int SZ_CHUNK_LSB = 16;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_SIZE = 2'd1;
  localparam logic [1:0] RA_SRC  = 2'd2;
  localparam logic [1:0] RA_DST  = 2'd3;
endpackage

// File: rtl/wdma_regs.sv
module wdma_regs
  import wdma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_CHUNK = 256,
  parameter int MAX_TOTAL = 4096,
  parameter int CHUNK_W   = $clog2(MAX_CHUNK + 1),
  parameter int TOTAL_W   = $clog2(MAX_TOTAL + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               busy,
  input  logic               fin_done,
  input  logic               fin_err,
  output logic               start,
  output logic               stop_req,
  output logic [ADDR_W-1:0]  src_base,
  output logic [ADDR_W-1:0]  dst_base,
  output logic [TOTAL_W-1:0] total,
  output logic [CHUNK_W-1:0] chunk,
  output logic               inc_src,
  output logic               inc_dst,
  output logic               src_sel,
  output logic               dst_sel,
  output logic               done,
  output logic               err,
  output logic               irq
);
  logic ie_done_q, ie_err_q;
  logic ctrl_wr, go_wr, size_ok, reject;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata;

  assign ctrl_wr  = reg_we && (reg_addr == RA_CTRL);
  assign go_wr    = ctrl_wr && reg_wdata[CTL_GO] && !busy;
  assign size_ok  = (chunk != '0) && (chunk <= CHUNK_W'(MAX_CHUNK)) &&
                    (total != '0) && (total <= TOTAL_W'(MAX_TOTAL));
  assign start    = go_wr && size_ok;
  assign reject   = go_wr && !size_ok;
  assign stop_req = ctrl_wr && reg_wdata[CTL_STOP] && busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_base  <= '0;
      dst_base  <= '0;
      total     <= '0;
      chunk     <= '0;
      inc_src   <= 1'b0;
      inc_dst   <= 1'b0;
      src_sel   <= 1'b0;
      dst_sel   <= 1'b0;
      ie_done_q <= 1'b0;
      ie_err_q  <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      if (reg_we && !busy) begin
        case (reg_addr)
          RA_CTRL: begin
            inc_src   <= reg_wdata[CTL_SINC];
            inc_dst   <= reg_wdata[CTL_DINC];
            src_sel   <= reg_wdata[CTL_SSEL];
            dst_sel   <= reg_wdata[CTL_DSEL];
            ie_done_q <= reg_wdata[CTL_IE_DONE];
            ie_err_q  <= reg_wdata[CTL_IE_ERR];
          end
          RA_SIZE: begin
            total <= reg_wdata[TOTAL_W-1:0];
            chunk <= reg_wdata[SZ_CHUNK_LSB +: CHUNK_W];
          end
          RA_SRC:  src_base <= reg_wdata[ADDR_W-1:0];
          default: dst_base <= reg_wdata[ADDR_W-1:0];
        endcase
      end
      if (start) begin
        done <= 1'b0;
        err  <= 1'b0;
      end else if (reject) begin
        done <= 1'b0;
        err  <= 1'b1;
      end else begin
        if (fin_done) done <= 1'b1;
        if (fin_err)  err  <= 1'b1;
      end
    end
  end

  assign irq = (done && ie_done_q) || (err && ie_err_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[CTL_SINC]    = inc_src;
        reg_rdata[CTL_DINC]    = inc_dst;
        reg_rdata[CTL_SSEL]    = src_sel;
        reg_rdata[CTL_DSEL]    = dst_sel;
        reg_rdata[CTL_IE_DONE] = ie_done_q;
        reg_rdata[CTL_IE_ERR]  = ie_err_q;
        reg_rdata[STA_BUSY]    = busy;
        reg_rdata[STA_DONE]    = done;
        reg_rdata[STA_ERR]     = err;
      end
      RA_SIZE: begin
        reg_rdata[TOTAL_W-1:0]                 = total;
        reg_rdata[SZ_CHUNK_LSB +: CHUNK_W]     = chunk;
      end
      RA_SRC:  reg_rdata[ADDR_W-1:0] = src_base;
      default: reg_rdata[ADDR_W-1:0] = dst_base;
    endcase
  end
endmodule

// File: rtl/wdma_mover.sv
module wdma_mover
  import wdma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int CHUNK_W = 9,
  parameter int TOTAL_W = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               stop_req,
  input  logic               inc_src,
  input  logic               inc_dst,
  input  logic [ADDR_W-1:0]  src_base,
  input  logic [ADDR_W-1:0]  dst_base,
  input  logic [TOTAL_W-1:0] total,
  input  logic [CHUNK_W-1:0] chunk,
  output logic               busy,
  output logic               fin_done,
  output logic               fin_err,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               mem_ack,
  input  logic               mem_err
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  mv_state_t           state_q;
  logic [TOTAL_W-1:0]  left_q;
  logic [CHUNK_W-1:0]  cnt_q;
  logic [ADDR_W-1:0]   src_q, dst_q;
  logic [DATA_W-1:0]   data_q;
  logic                stop_pend_q;
  logic                halt, wr_ok, last;

  assign halt  = stop_pend_q || stop_req;
  assign wr_ok = (state_q == ST_WR) && mem_ack && !mem_err;
  assign last  = (left_q == TOTAL_W'(1));

  assign busy      = (state_q != ST_IDLE);
  assign mem_req   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we    = (state_q == ST_WR);
  assign mem_addr  = (state_q == ST_WR) ? dst_q : src_q;
  assign mem_wdata = data_q;

  assign fin_done = wr_ok && last;
  assign fin_err  = (mem_req && mem_ack && mem_err) ||
                    (wr_ok && !last && halt) ||
                    ((state_q == ST_GAP) && halt);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      left_q      <= '0;
      cnt_q       <= '0;
      src_q       <= '0;
      dst_q       <= '0;
      data_q      <= '0;
      stop_pend_q <= 1'b0;
    end else begin
      if (state_q != ST_IDLE && stop_req) stop_pend_q <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q     <= ST_RD;
            src_q       <= src_base;
            dst_q       <= dst_base;
            left_q      <= total;
            cnt_q       <= chunk;
            stop_pend_q <= 1'b0;
          end
        end
        ST_RD: begin
          if (mem_ack) begin
            if (mem_err) state_q <= ST_IDLE;
            else begin
              data_q  <= mem_rdata;
              state_q <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (mem_ack) begin
            if (mem_err) state_q <= ST_IDLE;
            else begin
              left_q <= left_q - TOTAL_W'(1);
              src_q  <= src_q + (inc_src ? STEP : '0);
              dst_q  <= dst_q + (inc_dst ? STEP : '0);
              if (last || halt) state_q <= ST_IDLE;
              else if (cnt_q == CHUNK_W'(1)) begin
                state_q <= ST_GAP;
                cnt_q   <= chunk;
              end else begin
                state_q <= ST_RD;
                cnt_q   <= cnt_q - CHUNK_W'(1);
              end
            end
          end
        end
        default: state_q <= halt ? ST_IDLE : ST_RD;
      endcase
    end
  end
endmodule

// File: rtl/word_dma_chan.sv
module word_dma_chan #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_CHUNK = 256,
  parameter int MAX_TOTAL = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              src_sel,
  output logic              dst_sel,
  output logic              irq
);
  localparam int CHUNK_W = $clog2(MAX_CHUNK + 1);
  localparam int TOTAL_W = $clog2(MAX_TOTAL + 1);

  logic               busy, fin_done, fin_err, start, stop_req;
  logic               inc_src, inc_dst, done_flag, err_flag;
  logic [ADDR_W-1:0]  src_base, dst_base;
  logic [TOTAL_W-1:0] total;
  logic [CHUNK_W-1:0] chunk;

  wdma_regs #(
    .ADDR_W(ADDR_W), .MAX_CHUNK(MAX_CHUNK), .MAX_TOTAL(MAX_TOTAL),
    .CHUNK_W(CHUNK_W), .TOTAL_W(TOTAL_W)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .fin_done(fin_done), .fin_err(fin_err), .start(start), .stop_req(stop_req),
    .src_base(src_base), .dst_base(dst_base), .total(total), .chunk(chunk),
    .inc_src(inc_src), .inc_dst(inc_dst), .src_sel(src_sel), .dst_sel(dst_sel),
    .done(done_flag), .err(err_flag), .irq(irq)
  );

  wdma_mover #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHUNK_W(CHUNK_W), .TOTAL_W(TOTAL_W)
  ) u_mover (
    .clk(clk), .rst(rst), .start(start), .stop_req(stop_req),
    .inc_src(inc_src), .inc_dst(inc_dst), .src_base(src_base), .dst_base(dst_base),
    .total(total), .chunk(chunk), .busy(busy), .fin_done(fin_done), .fin_err(fin_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err)
  );
endmodule

// File: rtl/wdma_chk.sv
module wdma_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              irq,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              src_sel,
  input logic              dst_sel
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R13

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req && mem_we) |-> ($past(mem_ack) && !$past(mem_we))); // R2

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && err)); // R8

  AST_FLAGS_CLEAR_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!done && !err)); // R12

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    busy |-> !irq); // R10

  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(src_sel) && $stable(dst_sel))); // R11

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (!busy && $past(busy))); // R7
endmodule

bind word_dma_chan wdma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done_flag), .err(err_flag), .irq(irq),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .src_sel(src_sel), .dst_sel(dst_sel)
);

// File: tb/word_dma_chan_tb.sv
`timescale 1ns/1ps
module word_dma_chan_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;
  logic        src_sel, dst_sel, irq;

  always #5 clk = ~clk;

  word_dma_chan u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .src_sel(src_sel), .dst_sel(dst_sel), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  int rcnt = 0, wcnt = 0, falls = 0, idles = 0, hold_viol = 0;
  int exp_total = 0, err_at = -1, stall = 0;
  bit stall_on = 1'b1;
  logic [31:0] rd_log [0:4095];
  logic [31:0] wa_log [0:4095];
  logic [31:0] wd_log [0:4095];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h0BAD_F00D;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory responder, acts on falling edges only
  initial begin
    logic prev_req = 1'b0, pend = 1'b0, prev_we = 1'b0;
    logic [31:0] prev_addr = '0;
    forever begin
      @(negedge clk);
      if (pend && mem_req && (mem_addr != prev_addr || mem_we != prev_we)) hold_viol++;
      if (prev_req && !mem_req) falls++;
      if (!mem_req && rcnt > 0 && wcnt < exp_total && !rst) idles++;
      prev_req = mem_req;
      prev_addr = mem_addr;
      prev_we = mem_we;
      pend = 1'b0;
      if (mem_ack) begin
        mem_ack = 1'b0;
        mem_err = 1'b0;
      end else if (!rst && mem_req) begin
        if (stall > 0) begin
          stall--;
          pend = 1'b1;
        end else begin
          mem_err = ((rcnt + wcnt) == err_at);
          stall = stall_on ? ((rcnt + wcnt) % 3) : 0;
          if (mem_we) begin
            if (wcnt < 4096) begin wa_log[wcnt] = mem_addr; wd_log[wcnt] = mem_wdata; end
            wcnt++;
          end else begin
            if (rcnt < 4096) rd_log[rcnt] = mem_addr;
            mem_rdata = pat(mem_addr);
            rcnt++;
          end
          mem_ack = 1'b1;
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    summary();
    $finish;
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = 2'd0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      rd(2'd0, s);
      if (!s[10]) return;
    end
    chk(1'b0, "wait_idle timeout", 1, 0);
  endtask

  task automatic clear_logs(input int tot);
    rcnt = 0; wcnt = 0; falls = 0; idles = 0; exp_total = tot;
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input int tot, input int ck);
    wr(2'd2, s);
    wr(2'd3, d);
    wr(2'd1, (32'(ck) << 16) | 32'(tot));
  endtask

  task automatic check_copy(input string tag, input logic [31:0] s, input logic [31:0] d,
                            input int tot, input int ck, input bit is, input bit id);
    int bad_a = 0, bad_d = 0, nch;
    logic [31:0] st;
    nch = (tot + ck - 1) / ck;
    chk(rcnt == tot && wcnt == tot, {tag, " R2 word count"}, 32'(wcnt), 32'(tot));
    for (int i = 0; i < tot && i < 4096; i++) begin
      if (rd_log[i] != s + (is ? 32'(4 * i) : 32'd0)) bad_a++;
      if (wa_log[i] != d + (id ? 32'(4 * i) : 32'd0)) bad_a++;
      if (wd_log[i] != pat(rd_log[i])) bad_d++;
    end
    chk(bad_a == 0, {tag, " R3 address stepping"}, 32'(bad_a), 0);
    chk(bad_d == 0, {tag, " R2 data copied"}, 32'(bad_d), 0);
    chk(falls == nch, {tag, " R4 request drops"}, 32'(falls), 32'(nch));
    chk(idles == nch - 1, {tag, " R4 gap cycles"}, 32'(idles), 32'(nch - 1));
    rd(2'd0, st);
    chk(st[12:10] == 3'b010, {tag, " R7 done status"}, {29'd0, st[12:10]}, 32'b010);
  endtask

  initial begin
    logic [31:0] st, v;
    int tots [5] = '{1, 2, 3, 7, 9};
    int cks  [4] = '{1, 2, 4, 8};
    int k;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, st);
    chk(st[12:10] == 3'b000 && !mem_req && !irq, "R1 reset state", st, 0);

    // R1 start timing, R12 restart after an error
    clear_logs(0);
    wr(2'd1, 32'd0);
    wr(2'd0, 32'd1 | (32'd1 << 17));
    repeat (2) @(negedge clk);
    rd(2'd0, st);
    chk(st[12] && irq, "R5 reject zero size with error irq (R10)", st, 32'h1000);
    setup(32'h2000, 32'h3000, 5, 2);
    clear_logs(5);
    wr(2'd0, 32'd1 | (32'd1 << 17) | (32'd1 << 18) | (32'd1 << 4) | (32'd1 << 3));
    rd(2'd0, st);
    chk(st[12:10] == 3'b001 && !irq, "R12 start clears done error irq", st, 32'h400);
    chk(mem_req && !mem_we && mem_addr == 32'h2000, "R1 first read issued", mem_addr, 32'h2000);
    wait_idle();
    check_copy("first", 32'h2000, 32'h3000, 5, 2, 1'b1, 1'b1);
    chk(irq == 1'b1, "R10 irq on done enabled", 32'(irq), 1);

    // sweep over totals, chunk sizes and increment modes
    k = 0;
    foreach (tots[i]) begin
      foreach (cks[j]) begin
        bit is = k[0];
        bit id = k[1];
        logic [31:0] s = 32'h0001_0000 + 32'(k * 256);
        logic [31:0] d = 32'h0008_0000 + 32'(k * 512);
        setup(s, d, tots[i], cks[j]);
        clear_logs(tots[i]);
        wr(2'd0, 32'd1 | (32'(is) << 4) | (32'(id) << 3));
        wait_idle();
        check_copy($sformatf("sweep t%0d c%0d m%0d", tots[i], cks[j], k % 4),
                   s, d, tots[i], cks[j], is, id);
        k++;
      end
    end
    chk(irq == 1'b0, "R10 irq low with no enable", 32'(irq), 0);

    // R10 error enable only, successful transfer
    setup(32'h100, 32'h200, 3, 2);
    clear_logs(3);
    wr(2'd0, 32'd1 | (32'd1 << 17));
    wait_idle();
    chk(irq == 1'b0, "R10 irq low on done with only error enable", 32'(irq), 0);

    // R5 rejection cases
    for (int c = 0; c < 4; c++) begin
      int tt = (c == 2) ? 0 : (c == 3) ? 4097 : 4;
      int cc = (c == 0) ? 0 : (c == 1) ? 257 : 2;
      setup(32'h400, 32'h800, tt, cc);
      clear_logs(0);
      wr(2'd0, 32'd1 | (32'd1 << 18));
      repeat (4) @(negedge clk);
      rd(2'd0, st);
      chk(st[12:10] == 3'b100 && rcnt + wcnt == 0 && !mem_req,
          $sformatf("R5 reject t%0d c%0d", tt, cc), {29'd0, st[12:10]}, 32'b100);
      chk(irq == 1'b0, "R10 irq low on error with only done enable", 32'(irq), 0);
    end

    // R5 upper limits accepted, no stall
    stall_on = 1'b0;
    setup(32'h0010_0000, 32'h0020_0000, 4096, 256);
    clear_logs(4096);
    wr(2'd0, 32'd1 | (32'd1 << 4) | (32'd1 << 3));
    wait_idle();
    check_copy("R5 limits", 32'h0010_0000, 32'h0020_0000, 4096, 256, 1'b1, 1'b1);
    stall_on = 1'b1;

    // R6 writes ignored while busy, R11 selects held
    setup(32'h5000, 32'h6000, 20, 4);
    clear_logs(20);
    wr(2'd0, 32'd1 | (32'd1 << 4) | (32'd1 << 3) | (32'd1 << 2));
    chk(src_sel == 1'b1 && dst_sel == 1'b0, "R11 selects driven", {src_sel, dst_sel}, 2'b10);
    wr(2'd1, (32'd1 << 16) | 32'd5);
    wr(2'd2, 32'hDEAD_0000);
    wr(2'd0, 32'd2);
    chk(src_sel == 1'b1 && dst_sel == 1'b0, "R6 select write ignored while busy", {src_sel, dst_sel}, 2'b10);
    wait_idle();
    check_copy("R6 busy writes", 32'h5000, 32'h6000, 20, 4, 1'b1, 1'b1);
    rd(2'd1, v);
    chk(v == ((32'd4 << 16) | 32'd20), "R6 size register kept", v, (32'd4 << 16) | 32'd20);
    rd(2'd2, v);
    chk(v == 32'h5000, "R6 source register kept", v, 32'h5000);

    setup(32'h5000, 32'h6000, 3, 3);
    clear_logs(3);
    wr(2'd0, 32'd1 | (32'd1 << 1));
    chk(src_sel == 1'b0 && dst_sel == 1'b1, "R11 selects swapped", {src_sel, dst_sel}, 2'b01);
    wait_idle();

    // R8 software stop
    setup(32'h7000, 32'h7800, 40, 8);
    clear_logs(40);
    wr(2'd0, 32'd1 | (32'd1 << 4) | (32'd1 << 3));
    while (wcnt < 3) @(negedge clk);
    wr(2'd0, 32'd1 << 9);
    wait_idle();
    rd(2'd0, st);
    chk(st[12:10] == 3'b100, "R8 stop sets error not done", {29'd0, st[12:10]}, 32'b100);
    chk(wcnt < 40 && wcnt >= 3, "R8 stop ends early", 32'(wcnt), 40);
    chk(rcnt == wcnt, "R8 stop at word boundary", 32'(rcnt), 32'(wcnt));

    // R9 memory error on the third read (access index 4)
    setup(32'h9000, 32'h9800, 10, 4);
    clear_logs(10);
    err_at = 4;
    wr(2'd0, 32'd1 | (32'd1 << 4) | (32'd1 << 3));
    wait_idle();
    err_at = -1;
    repeat (3) @(negedge clk);
    rd(2'd0, st);
    chk(st[12:10] == 3'b100, "R9 bus error status", {29'd0, st[12:10]}, 32'b100);
    chk(rcnt == 3 && wcnt == 2, "R9 no access after error", 32'(rcnt * 16 + wcnt), 32'h32);

    chk(hold_viol == 0, "R13 request held until acknowledge", 32'(hold_viol), 0);

    summary();
    $finish;
  end
endmodule